// File: doc/BRIEF.md
# Fractional Divide Controller with Path-Swap Dither

This block is the digital core behind a fractional-N divider that cancels its own quantization noise. On every reference-cycle strobe a first-order phase accumulator adds a 16-bit fractional control word. Its overflow picks the divide ratio for the coming cycle: either the integer N or N+1. The wrapped accumulator value is the predicted phase error of that cycle. A first-order error-feedback requantizer reduces it to the resolution of a 128-unit current-steering DAC.

A 23-stage maximal-length LFSR advances on the same strobe. It yields a pseudo-random bit that exchanges two timing paths downstream. When that bit is set, the DAC code is mirrored so that the current follows the exchanged path. A test input can hold the swap bit at zero.

All outputs are registered. They change only on the clock edge that sees the strobe, and they hold between strobes. A valid pulse marks each update.

Top module: `frac_swap_ctl`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the requantizer error. It reloads the LFSR with its seed 0x05A5A5 and drives every output to zero.
- R2: On an edge with `ref_tick` high, the accumulator becomes (acc + frac_word) mod 65536. `div_carry` is 1 exactly when acc + frac_word is 65536 or more, and `div_value` = int_n + div_carry.
- R3: With frac_word = 0x4000, `div_carry` follows the pattern 0,0,0,1 and repeats it every four strobes.
- R4: The requantizer forms s = residue + e, where e is a 9-bit error state. It outputs level q = s >> 9, which lies in 0..128, and keeps e = s mod 512 for the next strobe.
- R5: `dac_code` equals q when `swap_path` is 0 and equals 128 − q when `swap_path` is 1. It never exceeds 128.
- R6: Each strobe shifts the LFSR state left by one place. The new bit 0 is state[22] XOR state[17], and `swap_path` takes the new bit 0. The state is never zero, and over many strobes the swap bit is set close to half the time.
- R7: While `swap_force_off` is high at a strobe, `swap_path` is 0 and `dac_code` equals q unmirrored. The LFSR still advances.
- R8: `out_valid` is high for exactly the one cycle after each strobe. Without a strobe, all other outputs hold their values.
- R9: Over any 32 consecutive strobes with frac_word = 0x2800, exactly 5 carries occur. With frac_word = 0, no carry occurs at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| frac_word | input | 16 | Fractional part of the divide ratio |
| int_n | input | 8 | Integer part of the divide ratio |
| swap_force_off | input | 1 | Holds the swap bit at zero when high |
| div_value | output | 9 | Divide ratio for the next reference cycle |
| div_carry | output | 1 | Accumulator overflow, which selects N+1 |
| dac_code | output | 8 | Units switched on in the cancellation DAC, 0..128 |
| swap_path | output | 1 | Timing-path exchange bit |
| out_valid | output | 1 | Pulses for one cycle after each update |

## Verification
A fraction of one quarter tells a correct carry position and period apart from an off-by-one accumulator. A fraction of 0x2800 run over long windows exposes carry counts that drift. A zero fraction and an all-ones fraction test the two extremes of overflow and requantizer range. Random fractions with gaps between strobes check that outputs hold. Runs with the swap bit forced off and left free separate a code mirrored by mistake from a correct one, and they also measure the duty cycle of the swap bit.

// File: rtl/frac_ctl_pkg.sv
package frac_ctl_pkg;
    localparam int ACC_W    = 16;
    localparam int INT_W    = 8;
    localparam int DAC_W    = 7;
    localparam int LFSR_W   = 23;
    localparam int LFSR_TAP = 18;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h05A5A5;
    localparam int CODE_W   = DAC_W + 1;
    localparam int ERR_W    = ACC_W - DAC_W;
    localparam int FULL     = 1 << DAC_W;

    typedef struct packed {
        logic [INT_W:0]    ratio;
        logic              carry;
        logic [CODE_W-1:0] code;
        logic              swap;
        logic              valid;
    } ctl_out_t;

    function automatic logic [CODE_W-1:0] steer_code(input logic [CODE_W-1:0] lvl,
                                                     input logic swp);
        return swp ? CODE_W'(FULL) - lvl : lvl;
    endfunction
endpackage

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] step,
    output logic [W-1:0] residue_nxt,
    output logic         carry_nxt
);
    logic [W-1:0] acc_q;

    always_comb begin
        {carry_nxt, residue_nxt} = {1'b0, acc_q} + {1'b0, step};
    end

    always_ff @(posedge clk) begin
        if (rst)      acc_q <= '0;
        else if (adv) acc_q <= residue_nxt;
    end

    // R2: an overflow leaves the accumulator below its previous value
    p_carry_wraps_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && carry_nxt) |=> (acc_q < $past(acc_q)));
    // R9: a zero step leaves the accumulator unchanged
    p_zero_step_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/frac_requant.sv
module frac_requant #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [IN_W-1:0] value,
    output logic [OUT_W:0]  level_nxt
);
    localparam int EW = IN_W - OUT_W;
    logic [EW-1:0] err_q;
    logic [IN_W:0] sum;

    always_comb begin
        sum       = {1'b0, value} + {{(OUT_W + 1){1'b0}}, err_q};
        level_nxt = sum[IN_W:EW];
    end

    always_ff @(posedge clk) begin
        if (rst)      err_q <= '0;
        else if (adv) err_q <= sum[EW-1:0];
    end

    // R4: the level never exceeds the full-scale unit count
    p_level_range_r4: assert property (@(posedge clk) disable iff (rst)
        level_nxt <= (OUT_W + 1)'(1 << OUT_W));
endmodule

// File: rtl/swap_lfsr.sv
module swap_lfsr #(
    parameter int W   = 23,
    parameter int TAP = 18,
    parameter logic [W-1:0] SEED = 23'h05A5A5
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_nxt
);
    logic [W-1:0] st_q;
    logic [W-1:0] st_nxt;

    always_comb begin
        st_nxt  = {st_q[W-2:0], st_q[W-1] ^ st_q[TAP-1]};
        bit_nxt = st_nxt[0];
    end

    always_ff @(posedge clk) begin
        if (rst)                       st_q <= SEED;
        else if (adv && st_nxt == '0)  st_q <= SEED;
        else if (adv)                  st_q <= st_nxt;
    end

    // R6: the register never enters the lock-up state
    p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        adv |=> (st_q != '0));
    // R6: the register only moves on a strobe
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(st_q));
endmodule

// File: rtl/frac_swap_ctl.sv
module frac_swap_ctl
    import frac_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [ACC_W-1:0]  frac_word,
    input  logic [INT_W-1:0]  int_n,
    input  logic              swap_force_off,
    output logic [INT_W:0]    div_value,
    output logic              div_carry,
    output logic [CODE_W-1:0] dac_code,
    output logic              swap_path,
    output logic              out_valid
);
    logic [ACC_W-1:0]  residue_nxt;
    logic              carry_nxt;
    logic [CODE_W-1:0] level_nxt;
    logic              rand_bit;
    logic              swap_nxt;
    ctl_out_t          out_q;

    frac_accum #(.W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .adv(ref_tick), .step(frac_word),
        .residue_nxt(residue_nxt), .carry_nxt(carry_nxt)
    );

    frac_requant #(.IN_W(ACC_W), .OUT_W(DAC_W)) u_rq (
        .clk(clk), .rst(rst), .adv(ref_tick), .value(residue_nxt),
        .level_nxt(level_nxt)
    );

    swap_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst(rst), .adv(ref_tick), .bit_nxt(rand_bit)
    );

    assign swap_nxt = rand_bit & ~swap_force_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= ref_tick;
            if (ref_tick) begin
                out_q.ratio <= {1'b0, int_n} + {{INT_W{1'b0}}, carry_nxt};
                out_q.carry <= carry_nxt;
                out_q.code  <= steer_code(level_nxt, swap_nxt);
                out_q.swap  <= swap_nxt;
            end
        end
    end

    assign div_value = out_q.ratio;
    assign div_carry = out_q.carry;
    assign dac_code  = out_q.code;
    assign swap_path = out_q.swap;
    assign out_valid = out_q.valid;

    // R5: the code to the DAC stays within 0..FULL
    p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
        dac_code <= CODE_W'(FULL));
    // R7: a forced strobe yields an unswapped path
    p_force_off_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && swap_force_off) |=> !swap_path);
    // R8: without a strobe the outputs hold
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> ($stable(dac_code) && $stable(div_value) && $stable(swap_path)));
    // R8: valid follows the strobe by one cycle
    p_valid_r8: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> out_valid);
    // R2: the ratio is N or N+1 according to the carry
    p_ratio_r2: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> (div_value == {1'b0, $past(int_n)} + {{INT_W{1'b0}}, div_carry}));
endmodule

// File: tb/frac_swap_ctl_test.sv
module frac_swap_ctl_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        ref_tick = 0;
    logic [15:0] frac_word = 0;
    logic [7:0]  int_n = 0;
    logic        swap_force_off = 0;
    logic [8:0]  div_value;
    logic        div_carry;
    logic [7:0]  dac_code;
    logic        swap_path;
    logic        out_valid;

    frac_swap_ctl uut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .frac_word(frac_word),
        .int_n(int_n), .swap_force_off(swap_force_off), .div_value(div_value),
        .div_carry(div_carry), .dac_code(dac_code), .swap_path(swap_path),
        .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state
    int acc_m, err_m, ratio_m, carry_m, code_m, swap_m, valid_m;
    int lfsr_m;
    string cur_req = "R2";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        acc_m = 0; err_m = 0; ratio_m = 0; carry_m = 0;
        code_m = 0; swap_m = 0; valid_m = 0; lfsr_m = 'h05A5A5;
    endtask

    task automatic model_tick();
        int s, q, nb;
        s = acc_m + frac_word;
        carry_m = s >= 65536 ? 1 : 0;
        acc_m = s % 65536;
        s = acc_m + err_m;
        q = s / 512;
        err_m = s % 512;
        nb = ((lfsr_m >> 22) ^ (lfsr_m >> 17)) & 1;
        lfsr_m = ((lfsr_m << 1) & 'h7FFFFF) | nb;
        swap_m = swap_force_off ? 0 : (lfsr_m & 1);
        code_m = swap_m ? 128 - q : q;
        ratio_m = int_n + carry_m;
    endtask

    task automatic compare_all();
        chk(div_value == ratio_m[8:0], cur_req, div_value, ratio_m);
        chk(div_carry == carry_m[0], cur_req, div_carry, carry_m);
        chk(dac_code == code_m[7:0], (cur_req == "R2") ? "R5" : cur_req, dac_code, code_m);
        chk(swap_path == swap_m[0], (cur_req == "R2") ? "R6" : cur_req, swap_path, swap_m);
        chk(out_valid == valid_m[0], "R8", out_valid, valid_m);
    endtask

    // one clock, entered and left at a falling edge
    task automatic step(input bit t);
        ref_tick = t;
        @(posedge clk);
        #1;
        valid_m = (t && !rst) ? 1 : 0;
        if (rst) model_reset();
        else if (t) model_tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1;
        step(0);
        step(1);
        rst = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt, ones, prev_code, saw_mirror;
        model_reset();
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(div_value == 0 && dac_code == 0 && !swap_path && !out_valid && !div_carry,
            "R1", {div_value, dac_code}, 0);

        // R3: quarter fraction, pattern 0,0,0,1
        cur_req = "R3";
        int_n = 8'd40; frac_word = 16'h4000;
        for (int i = 0; i < 12; i++) begin
            step(1);
            chk(div_carry == ((i % 4) == 3), "R3", div_carry, (i % 4) == 3);
            chk(div_value == 40 + ((i % 4) == 3), "R3", div_value, 40 + ((i % 4) == 3));
        end

        // R9: carry density at 0x2800
        cur_req = "R9";
        do_reset();
        frac_word = 16'h2800; int_n = 8'd17;
        for (int w = 0; w < 4; w++) begin
            cnt = 0;
            for (int i = 0; i < 32; i++) begin
                step(1);
                cnt += div_carry;
            end
            chk(cnt == 5, "R9", cnt, 5);
        end
        // R9: zero fraction never carries
        frac_word = 16'h0000;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            cnt += div_carry;
        end
        chk(cnt == 0, "R9", cnt, 0);

        // R4: all-ones fraction exercises full requantizer range
        cur_req = "R4";
        frac_word = 16'hFFFF; int_n = 8'd255;
        for (int i = 0; i < 64; i++) step(1);
        chk(div_value <= 256, "R4", div_value, 256);

        // R8: random fractions with idle gaps between strobes
        cur_req = "R8";
        for (int i = 0; i < 300; i++) begin
            frac_word = 16'($urandom);
            int_n = 8'($urandom);
            step(1);
            prev_code = dac_code;
            for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
                frac_word = 16'($urandom);
                step(0);
                chk(dac_code == prev_code[7:0], "R8", dac_code, prev_code);
            end
        end

        // R7: forced-off swap, LFSR keeps advancing
        cur_req = "R7";
        swap_force_off = 1;
        for (int i = 0; i < 100; i++) begin
            frac_word = 16'($urandom);
            step(1);
            chk(swap_path == 0, "R7", swap_path, 0);
        end
        swap_force_off = 0;

        // R6 / R5: duty cycle and mirrored codes
        cur_req = "R6";
        ones = 0; saw_mirror = 0;
        frac_word = 16'h1234; int_n = 8'd60;
        for (int i = 0; i < 2000; i++) begin
            step(1);
            ones += swap_path;
            if (swap_path && dac_code != 64) saw_mirror = 1;
        end
        chk(ones > 850 && ones < 1150, "R6", ones, 1000);
        chk(saw_mirror == 1, "R5", saw_mirror, 1);

        // R1: reset in mid-run restores seed and clears state
        cur_req = "R1";
        do_reset();
        chk(dac_code == 0 && div_value == 0 && !out_valid, "R1", dac_code, 0);
        frac_word = 16'h4000; int_n = 8'd3;
        for (int i = 0; i < 8; i++) step(1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule